// File: doc/BRIEF.md
# Seconds Real-Time Counter with Alarm

This block keeps wall-clock time as one long binary count driven by a slow time base. Each pulse on the tick input (one per period of a 32.768 kHz reference, presented as a single-cycle strobe in the system clock domain) advances the count by one. The upper field holds whole seconds and the lower field holds the fraction of a second. By default the seconds field is 32 bits and the fraction field is 15 bits, which makes a 47-bit count.

Software reaches the block through a small synchronous register port. The port has a seconds word, a fraction word, an alarm word, a control word and a status word. Counting halts whenever the enable is off, the power-on "time not valid" flag is still up, or the count has wrapped. A write to the seconds word loads the count and switches the enable on.

An alarm compares whole seconds only. When the seconds field reaches the programmed value, the alarm raises a sticky flag that the software clears by writing a one to it. An alarm value of all ones means that no alarm is set. Two lock bits stop the count from being altered while it is stopped. The soft lock can be cleared again, and the hard lock holds until reset.

Top module: `rtc_seconds_counter`

Register addresses: 0 seconds, 1 fraction, 2 alarm, 3 control, 4 status.
Control bits: bit 0 enable, bit 1 alarm interrupt enable, bit 2 soft lock, bit 3 hard lock.
Status bits: bit 0 alarm flag, bit 1 overflow, bit 2 not-valid. All status bits are cleared by writing 1 to them.

## Requirements
- R1: After reset the following values hold. The count is zero. The alarm word reads all ones. The control word reads 0. The status word reads 4, which means only the not-valid flag (bit 2) is set.
- R2: While running, each tick adds one to the count. The seconds word reads the count shifted right by the fraction width. The fraction word reads the low fraction-width bits of the count.
- R3: While control bit 0 (enable) is clear, ticks leave the count unchanged.
- R4: While status bit 2 (not-valid) is set, ticks leave the count unchanged. Writing 1 to status bit 2 clears the flag, and counting then resumes.
- R5: A tick at an all-ones count wraps the count to zero and sets status bit 1 (overflow). The count stays at zero until a write of 1 to status bit 1 clears the flag.
- R6: A write to the seconds word replaces the seconds field, keeps the fraction, and sets control bit 0. A write to the fraction word replaces only the fraction.
- R7: Status bit 0 (alarm flag) becomes set one clock after the seconds field becomes equal to the alarm word. An alarm word of all ones never sets the flag.
- R8: A status write clears exactly those flags whose data bits are 1. A written 0 leaves the flag unchanged.
- R9: The interrupt output is high exactly when the alarm flag and control bit 1 are both set.
- R10: A write to the seconds or fraction word is refused when control bit 2 or bit 3 is set and bit 0 is clear. With bit 0 set, such writes take effect.
- R11: Writing 0 clears control bit 2 (soft lock). Once control bit 3 (hard lock) is set, it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle time-base strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | SEC_W | Write data |
| rdata_o | output | SEC_W | Read data for addr_i (combinational) |
| alarm_irq_o | output | 1 | Alarm interrupt |

## Verification
The embedded assertions check on every cycle the per-tick increment, the hold of the count whenever it is stopped, stopped, not-valid or wrapped, the return to zero on a wrap, the seconds match behind every rise of the alarm flag, the refusal of locked writes, and the permanence of the hard lock. Other properties depend on a particular history of writes and ticks, so only the bench scenarios can show them. These include the exhaustive sweep of every count value in a reduced configuration, the unset alarm value that never fires, the selective clearing of status flags, and the interrupt gating.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    RA_SEC   = 3'd0,
    RA_FRAC  = 3'd1,
    RA_ALARM = 3'd2,
    RA_CTRL  = 3'd3,
    RA_STAT  = 3'd4
  } rtc_addr_e;

  localparam int CB_EN  = 0;
  localparam int CB_AIE = 1;
  localparam int CB_SLK = 2;
  localparam int CB_HLK = 3;

  localparam int SB_ALF = 0;
  localparam int SB_OVF = 1;
  localparam int SB_NVF = 2;
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15,
  localparam int CNT_W = SEC_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             ld_sec_i,
  input  logic             ld_frac_i,
  input  logic [SEC_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   nxt;
  logic             adv;

  // Increment with carry out; the carry marks a wrap from all ones.
  function automatic logic [CNT_W:0] step(input logic [CNT_W-1:0] v);
    return {1'b0, v} + {{CNT_W{1'b0}}, 1'b1};
  endfunction

  assign nxt    = step(cnt_q);
  assign adv    = tick_i && run_i && !ld_sec_i && !ld_frac_i;
  assign wrap_o = adv && nxt[CNT_W];
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ld_sec_i) begin
      cnt_q[CNT_W-1:FRAC_W] <= wdata_i;
    end else if (ld_frac_i) begin
      cnt_q[FRAC_W-1:0] <= wdata_i[FRAC_W-1:0];
    end else if (adv) begin
      cnt_q <= nxt[CNT_W-1:0];
    end
  end

  // R2: one step per running tick
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && run_i && !ld_sec_i && !ld_frac_i && !(&cnt_q))
      |=> cnt_q == $past(cnt_q) + 1'b1);
  // R3: no change without a running tick or a load
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick_i && run_i) && !ld_sec_i && !ld_frac_i) |=> $stable(cnt_q));
  // R5: a wrap lands on zero
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> cnt_q == '0);
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SEC_W-1:0] alarm_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic match;
  logic match_q;
  logic hit;

  assign match = (alarm_i != {SEC_W{1'b1}}) && (sec_i == alarm_i);
  assign hit   = match && !match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      flag_o  <= 1'b0;
    end else begin
      match_q <= match;
      if (hit)        flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  // R7: every rise of the flag follows a real seconds match
  a_r7_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(sec_i == alarm_i && alarm_i != {SEC_W{1'b1}}));
endmodule

// File: rtl/rtc_seconds_counter.sv
module rtc_seconds_counter
  import rtc_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [2:0]       addr_i,
  input  logic [SEC_W-1:0] wdata_i,
  output logic [SEC_W-1:0] rdata_o,
  output logic             alarm_irq_o
);
  localparam int CNT_W = SEC_W + FRAC_W;

  logic [CNT_W-1:0] cnt;
  logic [SEC_W-1:0] sec;
  logic [SEC_W-1:0] alarm_q;
  logic en_q, aie_q, slk_q, hlk_q, ovf_q, nvf_q;
  logic alarm_flag, wrap, run, lock_block;
  logic wr_sec, wr_frac, wr_alarm, wr_ctrl, wr_stat;
  logic ld_sec, ld_frac;

  assign sec        = cnt[CNT_W-1:FRAC_W];
  assign run        = en_q && !ovf_q && !nvf_q;
  assign lock_block = (slk_q || hlk_q) && !en_q;

  assign wr_sec   = wr_en_i && (addr_i == RA_SEC);
  assign wr_frac  = wr_en_i && (addr_i == RA_FRAC);
  assign wr_alarm = wr_en_i && (addr_i == RA_ALARM);
  assign wr_ctrl  = wr_en_i && (addr_i == RA_CTRL);
  assign wr_stat  = wr_en_i && (addr_i == RA_STAT);
  assign ld_sec   = wr_sec && !lock_block;
  assign ld_frac  = wr_frac && !lock_block;

  rtc_counter #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run),
    .ld_sec_i(ld_sec), .ld_frac_i(ld_frac), .wdata_i(wdata_i),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  rtc_alarm #(.SEC_W(SEC_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .sec_i(sec), .alarm_i(alarm_q),
    .clr_i(wr_stat && wdata_i[SB_ALF]), .flag_o(alarm_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '1;
      en_q    <= 1'b0;
      aie_q   <= 1'b0;
      slk_q   <= 1'b0;
      hlk_q   <= 1'b0;
      ovf_q   <= 1'b0;
      nvf_q   <= 1'b1;
    end else begin
      if (wr_alarm) alarm_q <= wdata_i;
      if (wr_ctrl) begin
        en_q  <= wdata_i[CB_EN];
        aie_q <= wdata_i[CB_AIE];
        slk_q <= wdata_i[CB_SLK];
        hlk_q <= hlk_q || wdata_i[CB_HLK];
      end else if (ld_sec) begin
        en_q <= 1'b1;
      end
      if (wrap)                             ovf_q <= 1'b1;
      else if (wr_stat && wdata_i[SB_OVF]) ovf_q <= 1'b0;
      if (wr_stat && wdata_i[SB_NVF])      nvf_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_SEC:   rdata_o = sec;
      RA_FRAC:  rdata_o[FRAC_W-1:0] = cnt[FRAC_W-1:0];
      RA_ALARM: rdata_o = alarm_q;
      RA_CTRL:  rdata_o[3:0] = {hlk_q, slk_q, aie_q, en_q};
      RA_STAT:  rdata_o[2:0] = {nvf_q, ovf_q, alarm_flag};
      default:  rdata_o = '0;
    endcase
  end

  assign alarm_irq_o = alarm_flag && aie_q;

  // R4: not-valid freezes the count
  a_r4_nv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (nvf_q && !ld_sec && !ld_frac) |=> $stable(cnt));
  // R5: overflow freezes the count
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ld_sec && !ld_frac) |=> $stable(cnt));
  // R10: locked, stopped counter refuses loads
  a_r10_lock_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_sec || wr_frac) && (slk_q || hlk_q) && !en_q) |=> $stable(cnt));
  // R11: hard lock is permanent until reset
  a_r11_hard_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hlk_q) |-> hlk_q);
endmodule

// File: tb/rtc_seconds_counter_bench.sv
module rtc_seconds_counter_bench;
  localparam int SW = 4;
  localparam int FW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [SW-1:0] wdata = '0;
  logic [SW-1:0] rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_seconds_counter #(.SEC_W(SW), .FRAC_W(FW)) u_rtc_seconds_counter (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .alarm_irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wdata = SW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = 3'(a);
    #1;
    v = int'(rdata);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_cnt(input string req, input int exp);
    int s, f;
    rd(0, s); rd(1, f);
    check(req, s, exp >> FW);
    check(req, f, exp & ((1 << FW) - 1));
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_cnt("R1", 0);
    rd(2, v); check("R1 alarm", v, (1 << SW) - 1);
    rd(3, v); check("R1 ctrl", v, 0);
    rd(4, v); check("R1 stat", v, 4);
    // R3: disabled
    ticks(5); chk_cnt("R3", 0);
    // R4: enabled but not-valid
    wr(3, 1); ticks(5); chk_cnt("R4", 0);
    wr(4, 4); rd(4, v); check("R4 nv cleared", v, 0);
    // R2: full sweep of every count value
    for (int i = 1; i < (1 << (SW + FW)); i++) begin
      ticks(1); chk_cnt("R2", i);
    end
    // R5: wrap
    ticks(1); chk_cnt("R5 wrap", 0);
    rd(4, v); check("R5 ovf", v, 2);
    ticks(3); chk_cnt("R5 frozen", 0);
    wr(4, 2); rd(4, v); check("R5 ovf clear", v, 0);
    ticks(1); chk_cnt("R5 resume", 1);
    // R3: disable
    wr(3, 0); ticks(4); chk_cnt("R3 disabled", 1);
    // R6: seconds load keeps fraction and enables
    wr(0, 9); chk_cnt("R6 sec load", (9 << FW) | 1);
    rd(3, v); check("R6 enable set", v, 1);
    wr(1, 0); chk_cnt("R6 frac load", 9 << FW);
    // R7: alarm match
    wr(2, 11);
    ticks(1 << FW); chk_cnt("R7 before", 10 << FW);
    rd(4, v); check("R7 no flag yet", v, 0);
    ticks(1 << FW);
    rd(4, v); check("R7 flag", v, 1);
    check("R9 irq masked", int'(irq), 0);
    wr(3, 3); check("R9 irq on", int'(irq), 1);
    wr(4, 6); rd(4, v); check("R8 zero keeps flag", v, 1);
    wr(4, 1); rd(4, v); check("R8 w1c", v, 0);
    check("R9 irq off", int'(irq), 0);
    // R7: unset alarm never fires
    wr(2, (1 << SW) - 1); wr(0, 14); wr(1, 0);
    ticks(1 << FW); chk_cnt("R7 at all ones", 15 << FW);
    rd(4, v); check("R7 unset", v, 0);
    // R10 / R11: locks
    wr(3, 5); wr(0, 3); chk_cnt("R10 enabled write", 3 << FW);
    wr(3, 4); wr(0, 7); wr(1, 5); chk_cnt("R10 soft refuse", 3 << FW);
    wr(3, 0); rd(3, v); check("R11 soft clear", v, 0);
    wr(0, 7); chk_cnt("R10 unlocked write", 7 << FW);
    wr(3, 8); wr(3, 0); rd(3, v); check("R11 hard sticky", v, 8);
    wr(0, 2); chk_cnt("R10 hard refuse", 7 << FW);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule